// File: doc/BRIEF.md
# Streaming Bayer-to-RGB Demosaic

This block takes a raster-order stream of 8-bit raw samples from a square image sensor whose colour filter follows the GBRG mosaic and returns one full 24-bit RGB pixel for every raw sample. The image side length `IMG_N` is a parameter. Two line memories hold the two previous rows. Together with the live sample they feed a 3x3 register window. A counter tracks the row and column of the window centre. The parity of that position selects the colour site, and an interpolation stage averages the same-colour neighbours that lie inside the image to fill in the two missing components.

Input samples are accepted whenever `valid_in` is high. Results leave in the same raster order, one per accepted sample, with a lag of `IMG_N+1` samples plus two register stages. When a new image follows the previous one without a pause, the new samples push out the tail of the old image. When the stream pauses right after the last sample of an image, the block drains the remaining `IMG_N+1` results by itself on consecutive clocks. `image_done` marks the last pixel of every image.

Top module: `bayer_demosaic`

## Requirements
- R1: After a synchronous reset, `valid_out` and `image_done` are low, and no result appears until the sample at row 1, column 1 of the first image has been accepted.
- R2: The colour site of the centre is picked by parity: even row with even column is green, even row with odd column is blue, odd row with even column is red, and odd row with odd column is green. `rgb_out` packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: At a green site the green output is the raw centre. On an even row, red is the mean of the pixels above and below and blue is the mean of the pixels left and right. On an odd row, red is the horizontal mean and blue is the vertical mean.
- R4: At a blue site, blue is the raw centre, green is the mean of the four orthogonal neighbours and red is the mean of the four diagonal neighbours. At a red site the same rule holds with red and blue swapped.
- R5: Neighbours outside the image are left out of the average. Each mean is the floor of the sum of the in-image neighbours divided by their count.
- R6: Results leave in raster order, exactly one per accepted sample, and each window position stays inside the image.
- R7: `image_done` is high for exactly one cycle, together with the result for row `IMG_N-1`, column `IMG_N-1`, and never without `valid_out`.
- R8: Images sent back to back, with no idle cycle between the last sample of one and the first sample of the next, are each processed correctly.
- R9: If `valid_in` is low in the cycle after an image's last sample, the remaining `IMG_N+1` results come out on consecutive cycles without further input.
- R10: Samples offered while that drain runs are dropped. The next image must start after the drain finishes and is then processed from its own first sample.
- R11: A low `valid_in` in the middle of an image stalls the pipeline without corrupting any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Raw sample on `pix_in` is offered |
| pix_in | input | 8 | Raw Bayer sample, raster order |
| rgb_out | output | 24 | Interpolated pixel {R,G,B} |
| valid_out | output | 1 | `rgb_out` holds a result |
| image_done | output | 1 | Result is the last pixel of an image |

## Verification
The embedded properties watch the invariants on every cycle. These are the single-cycle `image_done` tied to `valid_out`, the pass-through of the raw centre into the green channel at green sites, the window centre staying inside the image, and the drain counter staying bounded while the input position is frozen during a drain. The arithmetic of the averages, the edge handling, the raster order and the split between back-to-back streaming and drain can only be shown by the scoreboard. It compares every result against a reference model over images with stalls, continuous streaming, a colour-isolating pattern and samples injected during a drain.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [1:0] {
    SITE_G_EVEN = 2'b00,
    SITE_BLUE   = 2'b01,
    SITE_RED    = 2'b10,
    SITE_G_ODD  = 2'b11
  } site_t;

  function automatic site_t site_of(input logic row_odd, input logic col_odd);
    return site_t'({row_odd, col_odd});
  endfunction
endpackage

// File: rtl/dm_linebuf.sv
module dm_linebuf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] ra,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
    if (we) mem[wa] <= wd;
  end
endmodule

// File: rtl/dm_seq.sv
module dm_seq #(
  parameter int IMG_N = 8,
  parameter int PIX_W = 8,
  localparam int AW   = $clog2(IMG_N),
  localparam int CW   = $clog2(IMG_N + 1),
  localparam int LW   = $clog2(IMG_N + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [PIX_W-1:0] pix_in,
  output logic             step,
  output logic [AW-1:0]    rd_addr,
  output logic             shift,
  output logic             wr_en_q,
  output logic [AW-1:0]    addr_q,
  output logic [PIX_W-1:0] pix_q,
  output logic             win_valid,
  output logic [AW-1:0]    win_row,
  output logic [AW-1:0]    win_col
);
  localparam logic [AW-1:0] LAST = AW'(IMG_N - 1);
  localparam logic [CW-1:0] DLEN = CW'(IMG_N);
  localparam logic [LW-1:0] FILL = LW'(IMG_N + 1);

  logic [AW-1:0] in_row, in_col, out_row, out_col;
  logic [CW-1:0] dcnt;
  logic [LW-1:0] lead;
  logic          draining, tail_owed, last_q;
  logic          drain_go, take;

  assign drain_go = draining | (tail_owed & ~valid_in);
  assign take     = valid_in & ~drain_go;
  assign step     = drain_go | take;
  assign rd_addr  = drain_go ? ((dcnt < DLEN) ? dcnt[AW-1:0] : '0) : in_col;

  // Stage 0: input position, drain control, line-memory addressing
  always_ff @(posedge clk) begin
    if (rst) begin
      in_row <= '0; in_col <= '0; dcnt <= '0;
      draining <= 1'b0; tail_owed <= 1'b0;
      shift <= 1'b0; wr_en_q <= 1'b0; last_q <= 1'b0;
      addr_q <= '0; pix_q <= '0;
    end else begin
      shift   <= step;
      wr_en_q <= take;
      addr_q  <= rd_addr;
      pix_q   <= take ? pix_in : '0;
      last_q  <= drain_go && (dcnt == DLEN);
      if (take) begin
        tail_owed <= (in_row == LAST) && (in_col == LAST);
        if (in_col == LAST) begin
          in_col <= '0;
          in_row <= (in_row == LAST) ? '0 : in_row + 1'b1;
        end else begin
          in_col <= in_col + 1'b1;
        end
      end
      if (drain_go) begin
        tail_owed <= 1'b0;
        if (dcnt == DLEN) begin
          draining <= 1'b0;
          dcnt     <= '0;
        end else begin
          draining <= 1'b1;
          dcnt     <= dcnt + 1'b1;
        end
      end
    end
  end

  // Stage 1: window-centre position, lags the input by IMG_N+1 steps
  always_ff @(posedge clk) begin
    if (rst) begin
      lead <= '0; out_row <= '0; out_col <= '0;
      win_valid <= 1'b0; win_row <= '0; win_col <= '0;
    end else if (shift) begin
      if (lead != FILL) begin
        lead      <= lead + 1'b1;
        win_valid <= 1'b0;
      end else begin
        win_valid <= 1'b1;
        win_row   <= out_row;
        win_col   <= out_col;
        if (out_col == LAST) begin
          out_col <= '0;
          out_row <= (out_row == LAST) ? '0 : out_row + 1'b1;
        end else begin
          out_col <= out_col + 1'b1;
        end
        if (last_q) lead <= '0;
      end
    end else begin
      win_valid <= 1'b0;
    end
  end

  AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    draining |-> (dcnt <= DLEN)); // R9
  AST_DRAIN_FREEZES_INPUT: assert property (@(posedge clk) disable iff (rst)
    draining |=> (in_row == '0) && (in_col == '0)); // R10
  AST_CENTRE_IN_IMAGE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_row <= LAST) && (win_col <= LAST)); // R6
endmodule

// File: rtl/dm_interp.sv
module dm_interp #(
  parameter int IMG_N = 8,
  parameter int PIX_W = 8,
  localparam int AW   = $clog2(IMG_N),
  localparam int SW   = PIX_W + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0][2:0][PIX_W-1:0]  win,
  input  logic                        win_valid,
  input  logic [AW-1:0]               win_row,
  input  logic [AW-1:0]               win_col,
  output logic [3*PIX_W-1:0]          rgb_out,
  output logic                        valid_out,
  output logic                        image_done
);
  import dm_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(IMG_N - 1);

  function automatic logic [PIX_W-1:0] avg(input logic [SW-1:0] s, input logic [2:0] n);
    logic [SW-1:0] q;
    case (n)
      3'd2:    q = s >> 1;
      3'd3:    q = s / SW'(3);
      3'd4:    q = s >> 2;
      default: q = s;
    endcase
    return q[PIX_W-1:0];
  endfunction

  function automatic logic [SW-1:0] pick(input logic en, input logic [PIX_W-1:0] v);
    return en ? SW'(v) : '0;
  endfunction

  logic up, dn, lf, rt;
  logic [SW-1:0] sv, sh, sd;
  logic [2:0] nv, nh, nd;
  logic [PIX_W-1:0] a_v, a_h, a_o, a_d, ctr, r_c, g_c, b_c;
  site_t site;

  always_comb begin
    up  = (win_row != '0);
    dn  = (win_row != LAST);
    lf  = (win_col != '0);
    rt  = (win_col != LAST);
    sv  = pick(up, win[0][1]) + pick(dn, win[2][1]);
    sh  = pick(lf, win[1][0]) + pick(rt, win[1][2]);
    sd  = pick(up && lf, win[0][0]) + pick(up && rt, win[0][2])
        + pick(dn && lf, win[2][0]) + pick(dn && rt, win[2][2]);
    nv  = 3'(up) + 3'(dn);
    nh  = 3'(lf) + 3'(rt);
    nd  = 3'(up && lf) + 3'(up && rt) + 3'(dn && lf) + 3'(dn && rt);
    a_v = avg(sv, nv);
    a_h = avg(sh, nh);
    a_o = avg(sv + sh, nv + nh);
    a_d = avg(sd, nd);
    ctr = win[1][1];
    site = site_of(win_row[0], win_col[0]);
    case (site)
      SITE_G_EVEN: begin r_c = a_v; g_c = ctr; b_c = a_h; end
      SITE_G_ODD:  begin r_c = a_h; g_c = ctr; b_c = a_v; end
      SITE_BLUE:   begin r_c = a_d; g_c = a_o; b_c = ctr; end
      default:     begin r_c = ctr; g_c = a_o; b_c = a_d; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_out    <= '0;
      valid_out  <= 1'b0;
      image_done <= 1'b0;
    end else begin
      rgb_out    <= {r_c, g_c, b_c};
      valid_out  <= win_valid;
      image_done <= win_valid && (win_row == LAST) && (win_col == LAST);
    end
  end

  AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    image_done |-> valid_out); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    image_done |=> !image_done); // R7
  AST_GREEN_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (win_valid && (site == SITE_G_EVEN || site == SITE_G_ODD))
      |=> (rgb_out[2*PIX_W-1:PIX_W] == $past(win[1][1]))); // R3
endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic #(
  parameter int IMG_N = 8,
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_in,
  input  logic [PIX_W-1:0]   pix_in,
  output logic [3*PIX_W-1:0] rgb_out,
  output logic               valid_out,
  output logic               image_done
);
  localparam int AW    = $clog2(IMG_N);
  localparam int LINES = 2;

  logic             step, shift, wr_en_q, win_valid;
  logic [AW-1:0]    rd_addr, addr_q, win_row, win_col;
  logic [PIX_W-1:0] pix_q;
  logic [LINES-1:0][PIX_W-1:0] line_rd;
  logic [2:0][2:0][PIX_W-1:0]  win;

  dm_seq #(.IMG_N(IMG_N), .PIX_W(PIX_W)) seq_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .pix_in(pix_in),
    .step(step), .rd_addr(rd_addr), .shift(shift), .wr_en_q(wr_en_q),
    .addr_q(addr_q), .pix_q(pix_q), .win_valid(win_valid),
    .win_row(win_row), .win_col(win_col)
  );

  // Line k holds the row k+1 above the live one; writes trail reads by one cycle
  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic [PIX_W-1:0] wdata;
    if (k == 0) begin : g_first
      assign wdata = pix_q;
    end else begin : g_chain
      assign wdata = line_rd[k-1];
    end
    dm_linebuf #(.DEPTH(IMG_N), .DW(PIX_W)) lb_i (
      .clk(clk), .re(step), .ra(rd_addr),
      .we(wr_en_q), .wa(addr_q), .wd(wdata), .rd(line_rd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0;
    end else if (shift) begin
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
      end
      win[0][2] <= line_rd[1];
      win[1][2] <= line_rd[0];
      win[2][2] <= pix_q;
    end
  end

  dm_interp #(.IMG_N(IMG_N), .PIX_W(PIX_W)) interp_i (
    .clk(clk), .rst(rst), .win(win), .win_valid(win_valid),
    .win_row(win_row), .win_col(win_col),
    .rgb_out(rgb_out), .valid_out(valid_out), .image_done(image_done)
  );
endmodule

// File: tb/bayer_demosaic_tb.sv
`timescale 1ns/1ps
module bayer_demosaic_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [7:0]  pix_in = '0;
  logic [23:0] rgb_out;
  logic        valid_out, image_done;

  always #4 clk = ~clk;

  bayer_demosaic #(.IMG_N(N), .PIX_W(8)) dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .pix_in(pix_in),
    .rgb_out(rgb_out), .valid_out(valid_out), .image_done(image_done)
  );

  int tests = 0;
  int fails = 0;
  int out_seen = 0;
  int done_seen = 0;
  int cur [N][N];
  logic [24:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pv(int r, int c);
    if (r < 0 || r >= N || c < 0 || c >= N) return 0;
    return cur[r][c];
  endfunction

  // kind: 0 vertical, 1 horizontal, 2 orthogonal, 3 diagonal
  function automatic int mean(int r, int c, int kind);
    int s = 0, n = 0;
    int dr[4], dc[4], m;
    case (kind)
      0: begin dr = '{-1, 1, 0, 0}; dc = '{0, 0, 0, 0}; m = 2; end
      1: begin dr = '{0, 0, 0, 0};  dc = '{-1, 1, 0, 0}; m = 2; end
      2: begin dr = '{-1, 1, 0, 0}; dc = '{0, 0, -1, 1}; m = 4; end
      default: begin dr = '{-1, -1, 1, 1}; dc = '{-1, 1, -1, 1}; m = 4; end
    endcase
    for (int k = 0; k < m; k++) begin
      if (r + dr[k] >= 0 && r + dr[k] < N && c + dc[k] >= 0 && c + dc[k] < N) begin
        s += pv(r + dr[k], c + dc[k]);
        n++;
      end
    end
    return s / n;
  endfunction

  function automatic logic [23:0] ref_px(int r, int c);
    int rr, gg, bb;
    if (r % 2 == 0 && c % 2 == 0) begin rr = mean(r, c, 0); gg = cur[r][c]; bb = mean(r, c, 1); end
    else if (r % 2 == 1 && c % 2 == 1) begin rr = mean(r, c, 1); gg = cur[r][c]; bb = mean(r, c, 0); end
    else if (r % 2 == 0) begin rr = mean(r, c, 3); gg = mean(r, c, 2); bb = cur[r][c]; end
    else begin rr = cur[r][c]; gg = mean(r, c, 2); bb = mean(r, c, 3); end
    return {rr[7:0], gg[7:0], bb[7:0]};
  endfunction

  // Driver side: fill the image, queue its expected results
  task automatic load_image(input int kind, input string img_tag);
    int unsigned seed = 32'h1234_5678;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        seed = seed * 1103515245 + 12345;
        case (kind)
          0: cur[r][c] = (r * 37 + c * 11) & 255;
          1: cur[r][c] = (seed >> 16) & 255;
          2: cur[r][c] = ((r + c) % 2 == 0) ? 255 : 0;
          3: cur[r][c] = (r % 2 == 1 && c % 2 == 0) ? 200 : 3;
          default: cur[r][c] = (r * 16 + c + 5) & 255;
        endcase
      end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        string t;
        if (r == 0 || c == 0 || r == N - 1 || c == N - 1) t = "R5";
        else if (img_tag != "") t = img_tag;
        else if (r % 2 == c % 2) t = "R3";
        else t = "R4";
        exp_q.push_back({(r == N - 1 && c == N - 1), ref_px(r, c)});
        tag_q.push_back(t);
      end
  endtask

  task automatic drive_image(input int stall_every, input int hold_at);
    for (int i = 0; i < N * N; i++) begin
      if (stall_every > 0 && i % stall_every == stall_every - 1) begin
        @(negedge clk); valid_in = 1'b0;
      end
      @(negedge clk); valid_in = 1'b1; pix_in = 8'(cur[i / N][i % N]);
      if (i == hold_at) begin
        @(negedge clk); valid_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(out_seen == 0, "R1 early result", out_seen, 0);
      end
    end
  endtask

  task automatic idle_drain(input string req);
    @(negedge clk); valid_in = 1'b0;
    repeat (N + 4) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor side: pop and compare on every result
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      out_seen++;
      if (image_done) done_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected result", int'(rgb_out), 0);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rgb_out == e[23:0], t, int'(rgb_out), int'(e[23:0]));
        chk(image_done == e[24], "R7 done flag", int'(image_done), int'(e[24]));
      end
    end
  end

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(valid_out == 1'b0, "R1 valid after reset", int'(valid_out), 0);
    chk(image_done == 1'b0, "R1 done after reset", int'(image_done), 0);

    // Ramp with mid-image stalls and an early hold, then self drain
    load_image(0, "R11");
    drive_image(7, N);
    idle_drain("R9 tail drained");

    // Two images back to back, no idle between
    load_image(1, "");
    drive_image(0, -1);
    load_image(2, "R8");
    drive_image(0, -1);
    idle_drain("R8 stream tail");

    // Red-isolating pattern, then samples offered during the drain
    load_image(3, "R2");
    drive_image(0, -1);
    @(negedge clk); valid_in = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); valid_in = 1'b1; pix_in = 8'hAA;
    end
    idle_drain("R10 drain with offered samples");

    load_image(4, "R10");
    drive_image(3, -1);
    idle_drain("R9 final drain");

    chk(out_seen == 5 * N * N, "R6 result count", out_seen, 5 * N * N);
    chk(done_seen == 5, "R7 done count", done_seen, 5);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired, run did not finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule